// File: doc/BRIEF.md
# Group-Aligned Unit Fetch Address Generator

This block sits in front of an external memory controller in a wavelet-domain encoder. Coefficients are stored so that every unit of a prediction group lies back to back in memory. Each unit carries the blocks of all of its subbands. A request for "unit U of group G" therefore becomes one contiguous burst. Its address is a per-group base plus U times the group's unit size, and its length is that unit size in words. Addresses are counted in words.

An internal table holds one entry per group. Each entry has an original-frame base, a reconstructed-frame base and a unit size. Software or a setup engine fills the table through a write port. An entry whose size is zero counts as unconfigured.

One request can produce either one command or two. The first is always the original-frame command. When the request asks for both frames, the reconstructed-frame command follows it. Commands leave through a valid/ready handshake. A request for an unconfigured group raises an error pulse and issues nothing.

Top module: `unit_fetch_agen`

## Requirements
- R1: After reset, `cmdValid` and `errFlag` are low, `reqReady` is high while no table write is presented, and every table entry has unit size zero.
- R2: A cycle with `cfgWrEn` high stores the original base, reconstructed base and unit size into the entry selected by `cfgGroup`. All later requests to that group use these values.
- R3: While `cfgWrEn` is high, `reqReady` is low, so no request is accepted in that cycle.
- R4: In the cycle after a request to a configured group is accepted, the block presents a command. Its `cmdAddr` is original base + `reqUnit` × unit size, modulo 2^ADDR_W. Its `cmdLen` is the unit size, and `cmdFrame` is 0 (0 = original frame, 1 = reconstructed frame).
- R5: When `reqBoth` was 1 at acceptance, the original command's handshake is followed at once by a second command. That command has `cmdFrame` = 1, `cmdAddr` = reconstructed base + `reqUnit` × unit size, and the same length. When `reqBoth` was 0, only the original command is issued.
- R6: While `cmdValid` is high and `cmdReady` is low, the command's address, length and frame hold stable and `cmdValid` stays high.
- R7: `reqReady` is low while any command of the current request is still pending.
- R8: A request accepted for a group whose unit size is zero raises `errFlag` for exactly one cycle, in the cycle after acceptance, and produces no command.
- R9: A table write to a group while a command for that group is pending does not change the pending command.
- R10: The address sum wraps modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Table write strobe |
| cfgGroup | input | GID_W | Table entry index |
| cfgOrigBase | input | ADDR_W | Original-frame base address, in words |
| cfgReconBase | input | ADDR_W | Reconstructed-frame base address, in words |
| cfgUnitSize | input | SIZE_W | Unit size in words (0 = unconfigured) |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Request accepted when high with reqValid |
| reqGroup | input | GID_W | Requested group |
| reqUnit | input | UNIT_W | Unit index within the group |
| reqBoth | input | 1 | 1 = issue original and reconstructed commands |
| cmdValid | output | 1 | Burst command valid |
| cmdReady | input | 1 | Memory side accepts the command |
| cmdAddr | output | ADDR_W | Burst start address, in words |
| cmdLen | output | SIZE_W | Burst length, in words |
| cmdFrame | output | 1 | 0 = original frame, 1 = reconstructed frame |
| errFlag | output | 1 | One-cycle pulse for a request to an unconfigured group |

## Verification
Two functions can fall in the same cycle. A table write can coincide with an arriving request. A table write can also target the group whose command is waiting on back-pressure. The first case is provoked by raising `cfgWrEn` and `reqValid` together. It is judged by `reqReady` being low, followed by the next accepted command carrying the newly written values. The second case is provoked by rewriting the group's entry while `cmdReady` is held low. It is judged by the pending address and length staying at the old values, while later requests see the new ones. Random requests then mix configured and unconfigured groups, single and dual commands, and varying back-pressure. Each result is compared against a bench-side model of the table.

// File: rtl/agen_pkg.sv
package agen_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ORIG  = 2'd1,
    ST_RECON = 2'd2
  } agenState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch addresses and length for the accepted request
    logic selRecon;  // present the reconstructed-frame command
  } agenStrobes_t;

endpackage

// File: rtl/agen_ctrl.sv
module agen_ctrl
  import agen_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cfgWrEn,
  input  logic         reqValid,
  input  logic         reqBoth,
  input  logic         sizeZero,
  input  logic         cmdReady,
  output logic         reqReady,
  output logic         cmdValid,
  output logic         errFlag,
  output agenStrobes_t strobes
);

  agenState_t state, stateNext;
  logic       bothQ;
  logic       accept;

  assign reqReady = (state == ST_IDLE) && !cfgWrEn;
  assign accept   = reqReady && reqValid;
  assign cmdValid = (state != ST_IDLE);

  assign strobes.capture  = accept && !sizeZero;
  assign strobes.selRecon = (state == ST_RECON);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (strobes.capture) stateNext = ST_ORIG;
      ST_ORIG:  if (cmdReady) stateNext = bothQ ? ST_RECON : ST_IDLE;
      ST_RECON: if (cmdReady) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bothQ   <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      state   <= stateNext;
      errFlag <= accept && sizeZero;
      if (strobes.capture) bothQ <= reqBoth;
    end
  end

endmodule

// File: rtl/agen_datapath.sv
module agen_datapath
  import agen_pkg::*;
#(
  parameter int GROUPS = 16,
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 12,
  parameter int UNIT_W = 8,
  localparam int GID_W = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [GID_W-1:0]  cfgGroup,
  input  logic [ADDR_W-1:0] cfgOrigBase,
  input  logic [ADDR_W-1:0] cfgReconBase,
  input  logic [SIZE_W-1:0] cfgUnitSize,
  input  logic [GID_W-1:0]  reqGroup,
  input  logic [UNIT_W-1:0] reqUnit,
  input  agenStrobes_t      strobes,
  output logic              sizeZero,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [SIZE_W-1:0] cmdLen,
  output logic              cmdFrame
);

  localparam int PROD_W = UNIT_W + SIZE_W;

  logic [ADDR_W-1:0] origVec  [GROUPS];
  logic [ADDR_W-1:0] reconVec [GROUPS];
  logic [SIZE_W-1:0] sizeVec  [GROUPS];

  // one table entry per group
  for (genvar g = 0; g < GROUPS; g++) begin : gEntry
    logic [ADDR_W-1:0] origQ;
    logic [ADDR_W-1:0] reconQ;
    logic [SIZE_W-1:0] sizeQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        origQ  <= '0;
        reconQ <= '0;
        sizeQ  <= '0;
      end else if (cfgWrEn && (cfgGroup == GID_W'(g))) begin
        origQ  <= cfgOrigBase;
        reconQ <= cfgReconBase;
        sizeQ  <= cfgUnitSize;
      end
    end
    assign origVec[g]  = origQ;
    assign reconVec[g] = reconQ;
    assign sizeVec[g]  = sizeQ;
  end

  logic [SIZE_W-1:0] selSize;
  logic [PROD_W-1:0] unitOffset;
  logic [ADDR_W-1:0] offsetW;
  logic [ADDR_W-1:0] origAddrQ, reconAddrQ;
  logic [SIZE_W-1:0] lenQ;

  assign selSize    = sizeVec[reqGroup];
  assign sizeZero   = (selSize == '0);
  assign unitOffset = PROD_W'(reqUnit) * PROD_W'(selSize);
  assign offsetW    = ADDR_W'(unitOffset);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      origAddrQ  <= '0;
      reconAddrQ <= '0;
      lenQ       <= '0;
    end else if (strobes.capture) begin
      origAddrQ  <= origVec[reqGroup] + offsetW;
      reconAddrQ <= reconVec[reqGroup] + offsetW;
      lenQ       <= selSize;
    end
  end

  assign cmdAddr  = strobes.selRecon ? reconAddrQ : origAddrQ;
  assign cmdLen   = lenQ;
  assign cmdFrame = strobes.selRecon;

endmodule

// File: rtl/unit_fetch_agen.sv
module unit_fetch_agen
  import agen_pkg::*;
#(
  parameter int GROUPS = 16,
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 12,
  parameter int UNIT_W = 8,
  localparam int GID_W = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [GID_W-1:0]  cfgGroup,
  input  logic [ADDR_W-1:0] cfgOrigBase,
  input  logic [ADDR_W-1:0] cfgReconBase,
  input  logic [SIZE_W-1:0] cfgUnitSize,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [GID_W-1:0]  reqGroup,
  input  logic [UNIT_W-1:0] reqUnit,
  input  logic              reqBoth,
  output logic              cmdValid,
  input  logic              cmdReady,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [SIZE_W-1:0] cmdLen,
  output logic              cmdFrame,
  output logic              errFlag
);

  agenStrobes_t strobes;
  logic         sizeZero;

  agen_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWrEn  (cfgWrEn),
    .reqValid (reqValid),
    .reqBoth  (reqBoth),
    .sizeZero (sizeZero),
    .cmdReady (cmdReady),
    .reqReady (reqReady),
    .cmdValid (cmdValid),
    .errFlag  (errFlag),
    .strobes  (strobes)
  );

  agen_datapath #(
    .GROUPS (GROUPS),
    .ADDR_W (ADDR_W),
    .SIZE_W (SIZE_W),
    .UNIT_W (UNIT_W)
  ) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .cfgWrEn      (cfgWrEn),
    .cfgGroup     (cfgGroup),
    .cfgOrigBase  (cfgOrigBase),
    .cfgReconBase (cfgReconBase),
    .cfgUnitSize  (cfgUnitSize),
    .reqGroup     (reqGroup),
    .reqUnit      (reqUnit),
    .strobes      (strobes),
    .sizeZero     (sizeZero),
    .cmdAddr      (cmdAddr),
    .cmdLen       (cmdLen),
    .cmdFrame     (cmdFrame)
  );

endmodule

// File: rtl/agen_checker.sv
module agen_checker #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWrEn,
  input logic              reqReady,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic [ADDR_W-1:0] cmdAddr,
  input logic [SIZE_W-1:0] cmdLen,
  input logic              cmdFrame,
  input logic              errFlag
);

  // R3
  cfg_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |-> !reqReady);

  // R6
  hold_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> (cmdValid && $stable(cmdAddr) && $stable(cmdLen) && $stable(cmdFrame)));

  // R7
  busy_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> !reqReady);

  // R8
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> !errFlag);

  // R8
  err_no_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> !cmdValid);

  // R5
  recon_after_orig_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdFrame) |-> ($past(cmdValid) && ($past(cmdFrame) || !$past(cmdReady) || $past(!cmdFrame))));

  // R4
  len_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (cmdLen != '0));

endmodule

bind unit_fetch_agen agen_checker #(
  .ADDR_W (ADDR_W),
  .SIZE_W (SIZE_W)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .cfgWrEn  (cfgWrEn),
  .reqReady (reqReady),
  .cmdValid (cmdValid),
  .cmdReady (cmdReady),
  .cmdAddr  (cmdAddr),
  .cmdLen   (cmdLen),
  .cmdFrame (cmdFrame),
  .errFlag  (errFlag)
);

// File: tb/unit_fetch_agen_test.sv
`timescale 1ns/1ps
module unit_fetch_agen_test;

  localparam int GROUPS = 16;
  localparam int ADDR_W = 32;
  localparam int SIZE_W = 12;
  localparam int UNIT_W = 8;
  localparam int GID_W  = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cfgWrEn = 1'b0;
  logic [GID_W-1:0]  cfgGroup = '0;
  logic [ADDR_W-1:0] cfgOrigBase = '0;
  logic [ADDR_W-1:0] cfgReconBase = '0;
  logic [SIZE_W-1:0] cfgUnitSize = '0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic [GID_W-1:0]  reqGroup = '0;
  logic [UNIT_W-1:0] reqUnit = '0;
  logic              reqBoth = 1'b0;
  logic              cmdValid;
  logic              cmdReady = 1'b0;
  logic [ADDR_W-1:0] cmdAddr;
  logic [SIZE_W-1:0] cmdLen;
  logic              cmdFrame;
  logic              errFlag;

  always #2.5 clk = ~clk;

  unit_fetch_agen #(
    .GROUPS (GROUPS), .ADDR_W (ADDR_W), .SIZE_W (SIZE_W), .UNIT_W (UNIT_W)
  ) uut (
    .clk (clk), .rstN (rstN), .cfgWrEn (cfgWrEn), .cfgGroup (cfgGroup),
    .cfgOrigBase (cfgOrigBase), .cfgReconBase (cfgReconBase),
    .cfgUnitSize (cfgUnitSize), .reqValid (reqValid), .reqReady (reqReady),
    .reqGroup (reqGroup), .reqUnit (reqUnit), .reqBoth (reqBoth),
    .cmdValid (cmdValid), .cmdReady (cmdReady), .cmdAddr (cmdAddr),
    .cmdLen (cmdLen), .cmdFrame (cmdFrame), .errFlag (errFlag)
  );

  int checks = 0;
  int fails  = 0;

  logic [ADDR_W-1:0] mOrig  [GROUPS];
  logic [ADDR_W-1:0] mRecon [GROUPS];
  logic [SIZE_W-1:0] mSize  [GROUPS];

  function automatic logic [ADDR_W-1:0] expAddr(input logic [ADDR_W-1:0] base,
                                                 input int unit, input logic [SIZE_W-1:0] sz);
    logic [63:0] prod;
    prod = 64'(unit) * 64'(sz);
    return base + prod[ADDR_W-1:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chkCmd(input logic [ADDR_W-1:0] ea, input logic [SIZE_W-1:0] el,
                        input logic ef, input string req);
    chk(cmdValid == 1'b1, {req, " cmdValid"}, 64'(cmdValid), 64'd1);
    chk(cmdAddr == ea, {req, " cmdAddr"}, 64'(cmdAddr), 64'(ea));
    chk(cmdLen == el, {req, " cmdLen"}, 64'(cmdLen), 64'(el));
    chk(cmdFrame == ef, {req, " cmdFrame"}, 64'(cmdFrame), 64'(ef));
  endtask

  // R2: table write, one cycle
  task automatic cfgWrite(input int g, input logic [ADDR_W-1:0] ob,
                          input logic [ADDR_W-1:0] rb, input logic [SIZE_W-1:0] sz);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgGroup = GID_W'(g);
    cfgOrigBase = ob; cfgReconBase = rb; cfgUnitSize = sz;
    @(negedge clk);
    cfgWrEn = 1'b0;
    mOrig[g] = ob; mRecon[g] = rb; mSize[g] = sz;
  endtask

  task automatic runReq(input int g, input int u, input bit both, input int stall);
    logic [ADDR_W-1:0] eo, er;
    logic [SIZE_W-1:0] sz;
    sz = mSize[g];
    eo = expAddr(mOrig[g], u, sz);
    er = expAddr(mRecon[g], u, sz);
    @(negedge clk);
    reqValid = 1'b1; reqGroup = GID_W'(g); reqUnit = UNIT_W'(u); reqBoth = both;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    if (sz == '0) begin
      chk(errFlag == 1'b1, "R8 error pulse", 64'(errFlag), 64'd1);
      chk(cmdValid == 1'b0, "R8 no command", 64'(cmdValid), 64'd0);
      @(negedge clk);
      chk(errFlag == 1'b0, "R8 single cycle", 64'(errFlag), 64'd0);
      chk(cmdValid == 1'b0, "R8 still no command", 64'(cmdValid), 64'd0);
    end else begin
      chkCmd(eo, sz, 1'b0, "R4 orig");
      chk(reqReady == 1'b0, "R7 busy", 64'(reqReady), 64'd0);
      for (int i = 0; i < stall; i++) begin
        @(negedge clk);
        chkCmd(eo, sz, 1'b0, "R6 orig hold");
      end
      cmdReady = 1'b1;
      @(negedge clk);
      cmdReady = 1'b0;
      if (both) begin
        chkCmd(er, sz, 1'b1, "R5 recon");
        chk(reqReady == 1'b0, "R7 busy recon", 64'(reqReady), 64'd0);
        for (int i = 0; i < stall; i++) begin
          @(negedge clk);
          chkCmd(er, sz, 1'b1, "R6 recon hold");
        end
        cmdReady = 1'b1;
        @(negedge clk);
        cmdReady = 1'b0;
      end
      chk(cmdValid == 1'b0, "R5 command count", 64'(cmdValid), 64'd0);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20260311));
    for (int g = 0; g < GROUPS; g++) begin
      mOrig[g] = '0; mRecon[g] = '0; mSize[g] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cmdValid == 1'b0, "R1 cmdValid", 64'(cmdValid), 64'd0);
    chk(errFlag == 1'b0, "R1 errFlag", 64'(errFlag), 64'd0);
    chk(reqReady == 1'b1, "R1 reqReady", 64'(reqReady), 64'd1);
    // R1: all entries start unconfigured
    runReq(3, 2, 1'b1, 0);
    runReq(15, 0, 1'b0, 0);

    // R2, R4, R5 basic
    cfgWrite(1, 32'h0000_1000, 32'h0008_0000, 12'd64);
    runReq(1, 0, 1'b0, 0);
    runReq(1, 7, 1'b1, 2);

    // R3: write and request in the same cycle
    @(negedge clk);
    cfgWrEn = 1'b1; cfgGroup = 4'd2; cfgOrigBase = 32'h0002_0000;
    cfgReconBase = 32'h0003_0000; cfgUnitSize = 12'd48;
    reqValid = 1'b1; reqGroup = 4'd2; reqUnit = 8'd3; reqBoth = 1'b1;
    #0.1;
    chk(reqReady == 1'b0, "R3 stall on write", 64'(reqReady), 64'd0);
    @(negedge clk);
    cfgWrEn = 1'b0; reqValid = 1'b0;
    chk(cmdValid == 1'b0 && errFlag == 1'b0, "R3 nothing accepted", 64'({cmdValid, errFlag}), 64'd0);
    mOrig[2] = 32'h0002_0000; mRecon[2] = 32'h0003_0000; mSize[2] = 12'd48;
    runReq(2, 3, 1'b1, 1);

    // R10 wrap
    cfgWrite(4, 32'hFFFF_FFF0, 32'hFFFF_FFFC, 12'd8);
    runReq(4, 5, 1'b1, 0);
    // max unit, max size
    cfgWrite(5, 32'h1234_0000, 32'h8000_0000, 12'hFFF);
    runReq(5, 255, 1'b1, 0);

    // R9: rewrite group while its command is pending
    @(negedge clk);
    reqValid = 1'b1; reqGroup = 4'd1; reqUnit = 8'd2; reqBoth = 1'b1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    cfgWrEn = 1'b1; cfgGroup = 4'd1; cfgOrigBase = 32'h00AA_0000;
    cfgReconBase = 32'h00BB_0000; cfgUnitSize = 12'd16;
    @(negedge clk);
    cfgWrEn = 1'b0;
    chkCmd(expAddr(mOrig[1], 2, mSize[1]), mSize[1], 1'b0, "R9 orig unchanged");
    cmdReady = 1'b1;
    @(negedge clk);
    cmdReady = 1'b0;
    chkCmd(expAddr(mRecon[1], 2, mSize[1]), mSize[1], 1'b1, "R9 recon unchanged");
    cmdReady = 1'b1;
    @(negedge clk);
    cmdReady = 1'b0;
    mOrig[1] = 32'h00AA_0000; mRecon[1] = 32'h00BB_0000; mSize[1] = 12'd16;
    runReq(1, 2, 1'b0, 0);  // R2 new entry in use
    // R2: clearing an entry returns it to unconfigured
    cfgWrite(2, 32'h0, 32'h0, 12'd0);
    runReq(2, 1, 1'b1, 0);

    // random mix
    for (int n = 0; n < 300; n++) begin
      if ($urandom_range(0, 3) == 0) begin
        int g;
        g = int'($urandom_range(0, GROUPS - 1));
        cfgWrite(g, $urandom, $urandom,
                 ($urandom_range(0, 5) == 0) ? 12'd0 : SIZE_W'($urandom_range(1, 4095)));
      end
      runReq(int'($urandom_range(0, GROUPS - 1)), int'($urandom_range(0, 255)),
             1'($urandom_range(0, 1)), int'($urandom_range(0, 3)));
    end

    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule